// File: doc/BRIEF.md
# Pipelined Row-Sum Operand Scheduler

This block is the control heart of a streaming row reducer. Values arrive one per clock, each tagged with the row it belongs to, and wait in an order-keeping FIFO. One deeply pipelined adder does all the work. Every cycle the scheduler looks at three things:

- the sum leaving the last adder stage;
- whether a side buffer of partial results holds an entry for that sum's row;
- the oldest two FIFO entries.

From these it picks at most one operand pair to launch. Because several rows can be in flight in the adder at once, the adder's latency is hidden. A value with no partner yet is paired with the identity element, so that it still moves forward.

The choice follows a fixed priority ladder, evaluated combinationally in the same cycle:

1. Merge the adder output with its buffered partial.
2. Merge the adder output with the FIFO head.
3. Merge the two FIFO heads.
4. Pad the FIFO head with the identity element.
5. Idle.

The same cycle, the block tells the FIFO how many entries to pop. It also tells the buffer whether to release the matching partial, or to store the adder output because no rule took it. The chosen pair is registered, together with its row tag and a valid bit, and that register is the adder's first stage.

Top module: `reduce_sched`

## Requirements
- R1: When the adder output is valid and the buffer reports a partial for its row, the next issued pair is (a = adder output, b = buffered partial) with the adder output's row tag. `buf_take_o` is 1 and `pop_o` is 0 in the deciding cycle.
- R2: Otherwise, if the adder output is valid, the FIFO holds at least one entry and the head's tag equals the adder output's tag, the next pair is (a = adder output, b = head) with that tag, and `pop_o` is 1.
- R3: Otherwise, if the FIFO holds at least two entries with equal tags, the next pair is (a = head, b = second entry) with the head's tag, and `pop_o` is 2.
- R4: Otherwise, if the FIFO holds at least two entries, the next pair is (a = head, b = `IDENT`) with the head's tag, and `pop_o` is 1.
- R5: Otherwise nothing is issued. `iss_valid_o` is 0 on the following cycle, the issued operands and tag read as 0, and `pop_o` is 0.
- R6: A valid adder output that neither R1 nor R2 consumes is presented for storage in the same cycle: `buf_wr_o` is 1, with `buf_wr_tag_o` and `buf_wr_data_o` equal to the adder output's tag and data. `buf_wr_o` is 0 whenever the adder output is invalid or consumed.
- R7: The issued pair appears on the clock edge after the deciding cycle. Reset clears `iss_valid_o`, `iss_tag_o`, `iss_a_o` and `iss_b_o` to 0.
- R8: `pop_o` never exceeds `fifo_cnt_i`. The second FIFO entry is ignored when the count is below 2, and the head is ignored when the count is 0.
- R9: Closed in a loop with a FIFO, a partial buffer and an integer adder of any depth, the scheduler never drops or duplicates a value. After the stream drains, each row's data in the buffer, the FIFO and the pipeline sums to the row's input total, and the buffer is never asked to store a second partial for a row it already holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_cnt_i | input | CNT_W | Entries currently in the input FIFO |
| i1_tag_i | input | TAG_W | Row tag of the FIFO head |
| i1_data_i | input | DATA_W | Value at the FIFO head |
| i2_tag_i | input | TAG_W | Row tag of the second FIFO entry |
| i2_data_i | input | DATA_W | Value of the second FIFO entry |
| p_valid_i | input | 1 | Adder last stage holds a sum |
| p_tag_i | input | TAG_W | Row tag of the adder output |
| p_data_i | input | DATA_W | Adder output value |
| buf_hit_i | input | 1 | Buffer holds a partial for `p_tag_i` |
| buf_data_i | input | DATA_W | That buffered partial |
| iss_valid_o | output | 1 | Issued pair valid (adder stage 1) |
| iss_tag_o | output | TAG_W | Row tag of the issued pair |
| iss_a_o | output | DATA_W | First operand |
| iss_b_o | output | DATA_W | Second operand |
| pop_o | output | 2 | FIFO entries to remove this cycle |
| buf_take_o | output | 1 | Release the buffered partial for `p_tag_i` |
| buf_wr_o | output | 1 | Store the adder output in the buffer |
| buf_wr_tag_o | output | TAG_W | Row tag to store |
| buf_wr_data_o | output | DATA_W | Value to store |

## Verification
The checker watches several things on every cycle:

- `pop_o` stays within the FIFO count.
- A buffer release only happens on a hit, and never together with a pop.
- Every valid adder output is either consumed or stored.
- Two waiting entries always make progress unless rule 1 wins.
- An issue follows, one edge later, exactly the cycles in which something was consumed.
- The issued tag follows a buffer merge.

Only the bench's scenarios can show the rest. An exhaustive sweep over counts, tags, hit and valid shows that the exact operand values, their order and the priority between overlapping rules are right. A closed loop with a modelled FIFO, buffer and pipelined adder shows that interleaved row totals are conserved.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    RULE_BUF  = 3'd0,
    RULE_HEAD = 3'd1,
    RULE_PAIR = 3'd2,
    RULE_PAD  = 3'd3,
    RULE_IDLE = 3'd4
  } rule_e;
endpackage

// File: rtl/rs_rule_arb.sv
module rs_rule_arb
  import rs_pkg::*;
#(
  parameter int TAG_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [TAG_W-1:0] i1_tag_i,
  input  logic [TAG_W-1:0] i2_tag_i,
  input  logic             p_valid_i,
  input  logic [TAG_W-1:0] p_tag_i,
  input  logic             buf_hit_i,
  output rule_e            rule_o
);
  logic has_one, has_two;

  assign has_one = (fifo_cnt_i != '0);
  assign has_two = (fifo_cnt_i > CNT_W'(1));

  always_comb begin
    if (p_valid_i && buf_hit_i)                        rule_o = RULE_BUF;
    else if (p_valid_i && has_one && i1_tag_i == p_tag_i) rule_o = RULE_HEAD;
    else if (has_two && i1_tag_i == i2_tag_i)          rule_o = RULE_PAIR;
    else if (has_two)                                  rule_o = RULE_PAD;
    else                                               rule_o = RULE_IDLE;
  end
endmodule

// File: rtl/rs_operand_mux.sv
module rs_operand_mux
  import rs_pkg::*;
#(
  parameter int              DATA_W = 16,
  parameter int              TAG_W  = 3,
  parameter logic [DATA_W-1:0] IDENT = '0
) (
  input  rule_e             rule_i,
  input  logic [TAG_W-1:0]  i1_tag_i,
  input  logic [DATA_W-1:0] i1_data_i,
  input  logic [DATA_W-1:0] i2_data_i,
  input  logic              p_valid_i,
  input  logic [TAG_W-1:0]  p_tag_i,
  input  logic [DATA_W-1:0] p_data_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic              nxt_valid_o,
  output logic [TAG_W-1:0]  nxt_tag_o,
  output logic [DATA_W-1:0] nxt_a_o,
  output logic [DATA_W-1:0] nxt_b_o,
  output logic [1:0]        pop_o,
  output logic              take_o,
  output logic              wr_o
);
  always_comb begin
    nxt_valid_o = 1'b1;
    nxt_tag_o   = '0;
    nxt_a_o     = '0;
    nxt_b_o     = '0;
    pop_o       = 2'd0;
    take_o      = 1'b0;
    wr_o        = p_valid_i;
    unique case (rule_i)
      RULE_BUF: begin
        nxt_tag_o = p_tag_i;
        nxt_a_o   = p_data_i;
        nxt_b_o   = buf_data_i;
        take_o    = 1'b1;
        wr_o      = 1'b0;
      end
      RULE_HEAD: begin
        nxt_tag_o = p_tag_i;
        nxt_a_o   = p_data_i;
        nxt_b_o   = i1_data_i;
        pop_o     = 2'd1;
        wr_o      = 1'b0;
      end
      RULE_PAIR: begin
        nxt_tag_o = i1_tag_i;
        nxt_a_o   = i1_data_i;
        nxt_b_o   = i2_data_i;
        pop_o     = 2'd2;
      end
      RULE_PAD: begin
        nxt_tag_o = i1_tag_i;
        nxt_a_o   = i1_data_i;
        nxt_b_o   = IDENT;
        pop_o     = 2'd1;
      end
      default: nxt_valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rs_issue_reg.sv
module rs_issue_reg #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      a_o     <= '0;
      b_o     <= '0;
    end else begin
      valid_o <= valid_i;
      tag_o   <= tag_i;
      a_o     <= a_i;
      b_o     <= b_i;
    end
  end
endmodule

// File: rtl/reduce_sched.sv
module reduce_sched
  import rs_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                TAG_W  = 3,
  parameter int                CNT_W  = 4,
  parameter logic [DATA_W-1:0] IDENT  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  input  logic [TAG_W-1:0]  i1_tag_i,
  input  logic [DATA_W-1:0] i1_data_i,
  input  logic [TAG_W-1:0]  i2_tag_i,
  input  logic [DATA_W-1:0] i2_data_i,
  input  logic              p_valid_i,
  input  logic [TAG_W-1:0]  p_tag_i,
  input  logic [DATA_W-1:0] p_data_i,
  input  logic              buf_hit_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic              iss_valid_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  output logic [DATA_W-1:0] iss_a_o,
  output logic [DATA_W-1:0] iss_b_o,
  output logic [1:0]        pop_o,
  output logic              buf_take_o,
  output logic              buf_wr_o,
  output logic [TAG_W-1:0]  buf_wr_tag_o,
  output logic [DATA_W-1:0] buf_wr_data_o
);
  rule_e             rule;
  logic              nxt_valid;
  logic [TAG_W-1:0]  nxt_tag;
  logic [DATA_W-1:0] nxt_a, nxt_b;

  rs_rule_arb #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_arb (
    .fifo_cnt_i (fifo_cnt_i),
    .i1_tag_i   (i1_tag_i),
    .i2_tag_i   (i2_tag_i),
    .p_valid_i  (p_valid_i),
    .p_tag_i    (p_tag_i),
    .buf_hit_i  (buf_hit_i),
    .rule_o     (rule)
  );

  rs_operand_mux #(.DATA_W(DATA_W), .TAG_W(TAG_W), .IDENT(IDENT)) u_mux (
    .rule_i      (rule),
    .i1_tag_i    (i1_tag_i),
    .i1_data_i   (i1_data_i),
    .i2_data_i   (i2_data_i),
    .p_valid_i   (p_valid_i),
    .p_tag_i     (p_tag_i),
    .p_data_i    (p_data_i),
    .buf_data_i  (buf_data_i),
    .nxt_valid_o (nxt_valid),
    .nxt_tag_o   (nxt_tag),
    .nxt_a_o     (nxt_a),
    .nxt_b_o     (nxt_b),
    .pop_o       (pop_o),
    .take_o      (buf_take_o),
    .wr_o        (buf_wr_o)
  );

  // issue register doubles as adder stage 1
  rs_issue_reg #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (nxt_valid),
    .tag_i   (nxt_tag),
    .a_i     (nxt_a),
    .b_i     (nxt_b),
    .valid_o (iss_valid_o),
    .tag_o   (iss_tag_o),
    .a_o     (iss_a_o),
    .b_o     (iss_b_o)
  );

  assign buf_wr_tag_o  = p_tag_i;
  assign buf_wr_data_o = p_data_i;
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int TAG_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic [TAG_W-1:0] i1_tag_i,
  input logic             p_valid_i,
  input logic [TAG_W-1:0] p_tag_i,
  input logic             buf_hit_i,
  input logic             iss_valid_o,
  input logic [TAG_W-1:0] iss_tag_o,
  input logic [1:0]       pop_o,
  input logic             buf_take_o,
  input logic             buf_wr_o
);
  // R8
  pop_within_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{CNT_W{1'b0}}, pop_o} <= {2'b00, fifo_cnt_i});

  // R1
  take_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_take_o |-> (p_valid_i && buf_hit_i && pop_o == 2'd0));

  // R1
  take_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_take_o |=> (iss_valid_o && iss_tag_o == $past(p_tag_i)));

  // R6
  wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> (p_valid_i && !buf_take_o));

  // R6
  p_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_valid_i && !buf_wr_o) |-> (buf_take_o || (pop_o == 2'd1 && i1_tag_i == p_tag_i)));

  // R4
  two_progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_i > CNT_W'(1) && !buf_take_o) |-> (pop_o != 2'd0));

  // R7
  issue_after_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o != 2'd0 || buf_take_o) |=> iss_valid_o);

  // R5
  idle_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o == 2'd0 && !buf_take_o) |=> !iss_valid_o);
endmodule

bind reduce_sched rs_sched_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_cnt_i  (fifo_cnt_i),
  .i1_tag_i    (i1_tag_i),
  .p_valid_i   (p_valid_i),
  .p_tag_i     (p_tag_i),
  .buf_hit_i   (buf_hit_i),
  .iss_valid_o (iss_valid_o),
  .iss_tag_o   (iss_tag_o),
  .pop_o       (pop_o),
  .buf_take_o  (buf_take_o),
  .buf_wr_o    (buf_wr_o)
);

// File: tb/tb_reduce_sched.sv
module tb_reduce_sched;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 2;
  localparam int CNT_W  = 6;
  localparam int NTAG   = 1 << TAG_W;
  localparam int DEPTH  = 4;  // total adder stages incl. issue register
  localparam int NVAL   = 150;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [CNT_W-1:0]  fifo_cnt_i = '0;
  logic [TAG_W-1:0]  i1_tag_i = '0, i2_tag_i = '0, p_tag_i = '0;
  logic [DATA_W-1:0] i1_data_i = '0, i2_data_i = '0, p_data_i = '0, buf_data_i = '0;
  logic              p_valid_i = 1'b0, buf_hit_i = 1'b0;
  logic              iss_valid_o, buf_take_o, buf_wr_o;
  logic [TAG_W-1:0]  iss_tag_o, buf_wr_tag_o;
  logic [DATA_W-1:0] iss_a_o, iss_b_o, buf_wr_data_o;
  logic [1:0]        pop_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  reduce_sched #(.DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .IDENT('0)) dut (
    .clk_i, .rst_ni, .fifo_cnt_i, .i1_tag_i, .i1_data_i, .i2_tag_i, .i2_data_i,
    .p_valid_i, .p_tag_i, .p_data_i, .buf_hit_i, .buf_data_i,
    .iss_valid_o, .iss_tag_o, .iss_a_o, .iss_b_o, .pop_o, .buf_take_o,
    .buf_wr_o, .buf_wr_tag_o, .buf_wr_data_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // model state for the closed loop
  logic [TAG_W-1:0]  q_tag[$];
  logic [DATA_W-1:0] q_dat[$];
  logic              bv[NTAG];
  logic [DATA_W-1:0] bd[NTAG];
  logic              mv[DEPTH-1];
  logic [TAG_W-1:0]  mt[DEPTH-1];
  logic [DATA_W-1:0] md[DEPTH-1];
  logic [DATA_W-1:0] exp_sum[NTAG];

  task automatic loop_step(input bit push, input logic [TAG_W-1:0] nt, input logic [DATA_W-1:0] nd);
    int pn;
    bit tk, wr;
    @(negedge clk_i);
    fifo_cnt_i = (q_tag.size() > 63) ? CNT_W'(63) : CNT_W'(q_tag.size());
    i1_tag_i   = (q_tag.size() > 0) ? q_tag[0] : '0;
    i1_data_i  = (q_tag.size() > 0) ? q_dat[0] : '0;
    i2_tag_i   = (q_tag.size() > 1) ? q_tag[1] : '0;
    i2_data_i  = (q_tag.size() > 1) ? q_dat[1] : '0;
    p_valid_i  = mv[DEPTH-2];
    p_tag_i    = mt[DEPTH-2];
    p_data_i   = md[DEPTH-2];
    buf_hit_i  = mv[DEPTH-2] && bv[mt[DEPTH-2]];
    buf_data_i = bd[mt[DEPTH-2]];
    #1;
    pn = int'(pop_o);
    tk = buf_take_o;
    wr = buf_wr_o;
    if (wr) chk(!bv[p_tag_i], "R9 second partial stored", 1, 0);
    @(posedge clk_i);
    #1;
    for (int k = 0; k < pn; k++) begin
      void'(q_tag.pop_front());
      void'(q_dat.pop_front());
    end
    if (push) begin
      q_tag.push_back(nt);
      q_dat.push_back(nd);
    end
    if (tk) bv[p_tag_i] = 1'b0;
    if (wr) begin
      bv[p_tag_i] = 1'b1;
      bd[p_tag_i] = p_data_i;
    end
    for (int k = DEPTH-2; k > 0; k--) begin
      mv[k] = mv[k-1];
      mt[k] = mt[k-1];
      md[k] = md[k-1];
    end
    mv[0] = iss_valid_o;
    mt[0] = iss_tag_o;
    md[0] = iss_a_o + iss_b_o;
  endtask

  initial begin
    // reset state, R7
    repeat (3) @(negedge clk_i);
    chk(iss_valid_o == 1'b0, "R7 reset valid", iss_valid_o, 0);
    chk(iss_a_o == '0 && iss_b_o == '0 && iss_tag_o == '0, "R7 reset operands", iss_a_o, 0);
    rst_ni = 1'b1;

    // exhaustive sweep
    for (int c = 0; c < 4; c++)
    for (int pv = 0; pv < 2; pv++)
    for (int h = 0; h < 2; h++)
    for (int pt = 0; pt < NTAG; pt++)
    for (int t1 = 0; t1 < NTAG; t1++)
    for (int t2 = 0; t2 < NTAG; t2++) begin
      int rule, e_pop;
      logic [TAG_W-1:0]  e_tag;
      logic [DATA_W-1:0] e_a, e_b;
      @(negedge clk_i);
      fifo_cnt_i = CNT_W'(c);
      p_valid_i  = pv[0];
      buf_hit_i  = h[0];
      p_tag_i    = TAG_W'(pt);
      i1_tag_i   = TAG_W'(t1);
      i2_tag_i   = TAG_W'(t2);
      p_data_i   = DATA_W'(16'h3000 + pt);
      i1_data_i  = DATA_W'(16'h0100 + t1);
      i2_data_i  = DATA_W'(16'h0020 + t2);
      buf_data_i = DATA_W'(16'h4000 + c);
      if (pv == 1 && h == 1)                  rule = 1;
      else if (pv == 1 && c >= 1 && t1 == pt) rule = 2;
      else if (c >= 2 && t1 == t2)            rule = 3;
      else if (c >= 2)                        rule = 4;
      else                                    rule = 5;
      e_pop = (rule == 3) ? 2 : (rule == 2 || rule == 4) ? 1 : 0;
      e_tag = (rule <= 2) ? TAG_W'(pt) : (rule <= 4) ? TAG_W'(t1) : '0;
      e_a = (rule <= 2) ? p_data_i : (rule <= 4) ? i1_data_i : '0;
      e_b = (rule == 1) ? buf_data_i : (rule == 2) ? i1_data_i :
            (rule == 3) ? i2_data_i : '0;
      #1;
      case (rule)
        1: chk(pop_o == 0 && buf_take_o, "R1 pop/take", {pop_o, buf_take_o}, 1);
        2: chk(pop_o == 1 && !buf_take_o, "R2 pop", pop_o, 1);
        3: chk(pop_o == 2 && !buf_take_o, "R3 pop", pop_o, 2);
        4: chk(pop_o == 1 && !buf_take_o, "R4 pop", pop_o, 1);
        default: chk(pop_o == 0 && !buf_take_o, "R5 pop", pop_o, 0);
      endcase
      chk(int'(pop_o) <= c, "R8 pop vs count", pop_o, c);
      chk(buf_wr_o == (pv == 1 && rule > 2), "R6 store", buf_wr_o, (pv == 1 && rule > 2));
      if (buf_wr_o)
        chk(buf_wr_tag_o == TAG_W'(pt) && buf_wr_data_o == p_data_i, "R6 store fields",
            buf_wr_data_o, p_data_i);
      @(posedge clk_i);
      #1;
      chk(iss_valid_o == (rule != 5), "R7 issue valid", iss_valid_o, rule != 5);
      chk(iss_tag_o == e_tag, $sformatf("R%0d tag", rule), iss_tag_o, e_tag);
      chk(iss_a_o == e_a && iss_b_o == e_b, $sformatf("R%0d operands", rule),
          {iss_a_o, iss_b_o}, {e_a, e_b});
    end

    // closed loop with modelled fifo, buffer and adder, R9
    for (int k = 0; k < NTAG; k++) begin
      bv[k] = 1'b0;
      bd[k] = '0;
      exp_sum[k] = '0;
    end
    for (int k = 0; k < DEPTH-1; k++) begin
      mv[k] = 1'b0;
      mt[k] = '0;
      md[k] = '0;
    end
    for (int i = 0; i < NVAL; i++) begin
      logic [TAG_W-1:0]  t;
      logic [DATA_W-1:0] d;
      t = TAG_W'((i / 3 + i % 2) % NTAG);
      d = DATA_W'(i * 37 + 5);
      exp_sum[t] = exp_sum[t] + d;
      loop_step(1'b1, t, d);
    end
    for (int i = 0; i < 40; i++) loop_step(1'b0, '0, '0);
    for (int k = 0; k < NTAG; k++) begin
      logic [DATA_W-1:0] tot;
      tot = bv[k] ? bd[k] : '0;
      foreach (q_tag[j]) if (q_tag[j] == TAG_W'(k)) tot = tot + q_dat[j];
      for (int s = 0; s < DEPTH-1; s++) if (mv[s] && mt[s] == TAG_W'(k)) tot = tot + md[s];
      chk(tot == exp_sum[k], $sformatf("R9 row %0d total", k), tot, exp_sum[k]);
    end
    finish_run();
  end
endmodule